// File: doc/BRIEF.md
# Multicycle Indexed Load Unit

This block carries out one register-based load at a time over several clock cycles. A 16-bit instruction word, presented with a start strobe, names a destination register, a base register, an index register and a signed 6-bit displacement. One mode bit selects between two address forms. The indexed form adds base, index and displacement. The plain form adds only base and displacement.

The computed effective address goes into an address holding register, which drives a synchronous memory read port. The returned word is caught in a data holding register one cycle later. It is then written into the destination entry of an internal eight-entry register file. A separate write port and a read port on the register file let the surrounding logic preload operands and observe results. The unit reports `busy` while a load is in flight and pulses `done` once the write has happened.

Top module: `lu_load_unit`

## Requirements
- R1: Instruction encoding: bit 15 is the mode (1 = indexed, 0 = plain), bits [14:12] the destination register, bits [11:9] the base register, bits [8:6] the index register, and bits [5:0] a two's-complement displacement.
- R2: In indexed mode the address presented on `mem_addr` is R[base] + R[index] + sign-extended displacement, taken modulo 2^16.
- R3: In plain mode the address is R[base] + sign-extended displacement; the index field and R[index] have no effect on the address.
- R4: When `start` is sampled high while idle, `mem_rd` is high for exactly one cycle, which is the second cycle after that edge, with `mem_addr` holding the effective address. The memory word returned on `mem_rdata` one cycle later is captured.
- R5: The captured word is written to R[dest]. The new value is readable on `rf_rdata` in the cycle where `done` is high, whatever R[dest] held before.
- R6: `busy` is high for the four cycles after the accepting edge. `done` is high for exactly the one cycle that follows. A `start` seen while `busy` is high is ignored.
- R7: The external write port (`rf_we`, `rf_waddr`, `rf_wdata`) updates any register, register 0 included, when the unit is not busy. It is ignored while `busy` is high.
- R8: After reset `busy`, `done` and `mem_rd` are low and every register reads zero.
- R9: A destination equal to the base or index register still uses that register's pre-load value for the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a load with `instr` |
| instr | input | 16 | Load instruction word |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 16 | Memory read address (address holding register) |
| mem_rd | output | 1 | Memory read enable |
| mem_rdata | input | 16 | Memory read data, one cycle after `mem_rd` |
| rf_we | input | 1 | External register write enable |
| rf_waddr | input | 3 | External register write index |
| rf_wdata | input | 16 | External register write data |
| rf_raddr | input | 3 | External register read index |
| rf_rdata | output | 16 | External register read data (combinational) |

## Verification
A wrong address sum, a bad displacement sign extension or a mode decoded the wrong way shows on `mem_addr` in the cycle where `mem_rd` is high, two cycles after the start. A data holding register that misses its capture, or a write sent to the wrong register, shows on `rf_rdata` in the cycle where `done` is high. A sequencer that restarts or stalls shows as a `busy` window other than four cycles. A write port that is not blocked while busy shows up when the poked register is read after the load. The bench sweeps every displacement in both modes and every destination, and computes memory contents arithmetically from the address.

// File: rtl/lu_pkg.sv
// Package: shared types for the load unit.
// Assumes a fixed 16-bit instruction layout with 3-bit register fields.
package lu_pkg;

    localparam int INSTR_W = 16;
    localparam int RSEL_W  = 3;
    localparam int DISP_W  = 6;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_READ = 3'd2,
        ST_CAPT = 3'd3,
        ST_WB   = 3'd4,
        ST_DONE = 3'd5
    } lu_state_e;

    typedef struct packed {
        logic              indexed;
        logic [RSEL_W-1:0] dst;
        logic [RSEL_W-1:0] base;
        logic [RSEL_W-1:0] idx;
        logic [DISP_W-1:0] disp;
    } lu_instr_t;

endpackage

// File: rtl/lu_decode.sv
// Module: lu_decode
// Splits the held instruction word into its fields and sign-extends the
// displacement to the address width. Assumes AW >= DISP_W.
module lu_decode
    import lu_pkg::*;
#(
    parameter int AW = 16
) (
    input  lu_instr_t         ir,
    output logic              indexed,
    output logic [RSEL_W-1:0] dst,
    output logic [RSEL_W-1:0] base_sel,
    output logic [RSEL_W-1:0] idx_sel,
    output logic [AW-1:0]     disp_ext
);
    localparam int EXT_W = AW - DISP_W;

    // Field extraction and displacement sign extension.
    always_comb begin
        indexed  = ir.indexed;
        dst      = ir.dst;
        base_sel = ir.base;
        idx_sel  = ir.idx;
        disp_ext = {{EXT_W{ir.disp[DISP_W-1]}}, ir.disp};
    end
endmodule

// File: rtl/lu_agu.sv
// Module: lu_agu
// Effective address adder. Adds the base value, the index value when
// indexed mode is selected, and the extended displacement, wrapping at AW.
module lu_agu #(
    parameter int AW = 16
) (
    input  logic          indexed,
    input  logic [AW-1:0] base_val,
    input  logic [AW-1:0] idx_val,
    input  logic [AW-1:0] disp_ext,
    output logic [AW-1:0] ea
);
    logic [AW-1:0] idx_term;

    // Gate the index term by mode, then form the three-way sum.
    always_comb begin
        idx_term = indexed ? idx_val : '0;
        ea       = base_val + idx_term + disp_ext;
    end
endmodule

// File: rtl/lu_regfile.sv
// Module: lu_regfile
// NREG x DW register file with three combinational read ports and one
// write port fed from two sources: the load write-back (priority) and an
// external write that is honoured only when ext_ok is high.
// Assumes synchronous active-low reset clears every entry.
module lu_regfile #(
    parameter int NREG = 8,
    parameter int DW   = 16,
    localparam int SW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_we,
    input  logic [SW-1:0] ld_waddr,
    input  logic [DW-1:0] ld_wdata,
    input  logic          ext_ok,
    input  logic          ext_we,
    input  logic [SW-1:0] ext_waddr,
    input  logic [DW-1:0] ext_wdata,
    input  logic [SW-1:0] ra_a,
    output logic [DW-1:0] rd_a,
    input  logic [SW-1:0] ra_b,
    output logic [DW-1:0] rd_b,
    input  logic [SW-1:0] ra_c,
    output logic [DW-1:0] rd_c
);
    logic [DW-1:0] regs [NREG];

    // Each entry decodes its own write enable; load write-back wins.
    for (genvar g = 0; g < NREG; g++) begin : g_entry
        logic hit_ld;
        logic hit_ext;
        assign hit_ld  = ld_we && (ld_waddr == SW'(g));
        assign hit_ext = ext_ok && ext_we && (ext_waddr == SW'(g));

        // Entry storage update.
        always_ff @(posedge clk) begin
            if (!rst_n)       regs[g] <= '0;
            else if (hit_ld)  regs[g] <= ld_wdata;
            else if (hit_ext) regs[g] <= ext_wdata;
        end
    end

    // Read ports.
    always_comb begin
        rd_a = regs[ra_a];
        rd_b = regs[ra_b];
        rd_c = regs[ra_c];
    end
endmodule

// File: rtl/lu_ctrl.sv
// Module: lu_ctrl
// Sequencer for one load: ADDR (address into MAR), READ (memory port
// presented), CAPT (read data into MDR), WB (MDR into register), DONE.
// Accepts start only in IDLE or DONE; start in any other state is ignored.
module lu_ctrl
    import lu_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    output lu_state_e state,
    output logic      ld_ir,
    output logic      ld_mar,
    output logic      ld_mdr,
    output logic      wr_rf,
    output logic      mem_rd,
    output logic      busy,
    output logic      done
);
    lu_state_e nxt;
    logic      accept;

    // Next-state selection.
    always_comb begin
        accept = start && ((state == ST_IDLE) || (state == ST_DONE));
        nxt    = state;
        unique case (state)
            ST_IDLE: nxt = accept ? ST_ADDR : ST_IDLE;
            ST_ADDR: nxt = ST_READ;
            ST_READ: nxt = ST_CAPT;
            ST_CAPT: nxt = ST_WB;
            ST_WB:   nxt = ST_DONE;
            ST_DONE: nxt = accept ? ST_ADDR : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Step strobes and status decoded from the current state.
    always_comb begin
        ld_ir  = accept;
        ld_mar = (state == ST_ADDR);
        mem_rd = (state == ST_READ);
        ld_mdr = (state == ST_CAPT);
        wr_rf  = (state == ST_WB);
        busy   = (state == ST_ADDR) || (state == ST_READ) ||
                 (state == ST_CAPT) || (state == ST_WB);
        done   = (state == ST_DONE);
    end
endmodule

// File: rtl/lu_load_unit.sv
// Module: lu_load_unit (top)
// Multicycle load unit: holds the accepted instruction, forms the effective
// address, loads it into MAR, reads a synchronous memory with one cycle of
// latency into MDR, and writes MDR into the destination register.
// Assumes the memory returns mem_rdata one clock after mem_rd/mem_addr.
module lu_load_unit
    import lu_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NREG = 8,
    localparam int SW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [15:0]   instr,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] mem_addr,
    output logic          mem_rd,
    input  logic [DW-1:0] mem_rdata,
    input  logic          rf_we,
    input  logic [SW-1:0] rf_waddr,
    input  logic [DW-1:0] rf_wdata,
    input  logic [SW-1:0] rf_raddr,
    output logic [DW-1:0] rf_rdata
);
    lu_state_e         state_q;
    lu_instr_t         ir_q;
    logic [DW-1:0]     mar_q;
    logic [DW-1:0]     mdr_q;
    logic              ld_ir, ld_mar, ld_mdr, wr_rf;
    logic              indexed;
    logic [RSEL_W-1:0] dst, base_sel, idx_sel;
    logic [DW-1:0]     disp_ext, base_val, idx_val, ea;

    lu_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .state  (state_q),
        .ld_ir  (ld_ir),
        .ld_mar (ld_mar),
        .ld_mdr (ld_mdr),
        .wr_rf  (wr_rf),
        .mem_rd (mem_rd),
        .busy   (busy),
        .done   (done)
    );

    // Instruction holding register, loaded when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)     ir_q <= '0;
        else if (ld_ir) ir_q <= lu_instr_t'(instr);
    end

    lu_decode #(.AW(DW)) u_dec (
        .ir       (ir_q),
        .indexed  (indexed),
        .dst      (dst),
        .base_sel (base_sel),
        .idx_sel  (idx_sel),
        .disp_ext (disp_ext)
    );

    lu_regfile #(.NREG(NREG), .DW(DW)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_we     (wr_rf),
        .ld_waddr  (SW'(dst)),
        .ld_wdata  (mdr_q),
        .ext_ok    (!busy),
        .ext_we    (rf_we),
        .ext_waddr (rf_waddr),
        .ext_wdata (rf_wdata),
        .ra_a      (SW'(base_sel)),
        .rd_a      (base_val),
        .ra_b      (SW'(idx_sel)),
        .rd_b      (idx_val),
        .ra_c      (rf_raddr),
        .rd_c      (rf_rdata)
    );

    lu_agu #(.AW(DW)) u_agu (
        .indexed  (indexed),
        .base_val (base_val),
        .idx_val  (idx_val),
        .disp_ext (disp_ext),
        .ea       (ea)
    );

    // Step one: effective address into MAR.
    always_ff @(posedge clk) begin
        if (!rst_n)      mar_q <= '0;
        else if (ld_mar) mar_q <= ea;
    end

    // Step two: memory word into MDR.
    always_ff @(posedge clk) begin
        if (!rst_n)      mdr_q <= '0;
        else if (ld_mdr) mdr_q <= mem_rdata;
    end

    // MAR drives the memory address port.
    assign mem_addr = mar_q;
endmodule

// File: rtl/lu_load_unit_chk.sv
// Module: lu_load_unit_chk
// Protocol checker for lu_load_unit, bound to every instance.
module lu_load_unit_chk
    import lu_pkg::*;
#(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          mem_rd,
    input logic [DW-1:0] mem_rdata,
    input logic [DW-1:0] mar_q,
    input logic [DW-1:0] mdr_q,
    input lu_state_e     state_q
);
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_busy_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (state_q != ST_ADDR));

    a_r4_read_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    a_r4_mar_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> $stable(mar_q));

    a_r4_mdr_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CAPT) |=> (mdr_q == $past(mem_rdata)));

    a_r6_read_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> busy);
endmodule

bind lu_load_unit lu_load_unit_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .mem_rd    (mem_rd),
    .mem_rdata (mem_rdata),
    .mar_q     (mar_q),
    .mdr_q     (mdr_q),
    .state_q   (state_q)
);

// File: tb/tb_lu_load_unit.sv
// Bench: sweeps every displacement in both modes plus every destination,
// with memory contents computed from the address.
module tb_lu_load_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic        busy, done, mem_rd;
    logic [15:0] mem_addr, mem_rdata, rf_rdata;
    logic        rf_we = 1'b0;
    logic [2:0]  rf_waddr = '0, rf_raddr = '0;
    logic [15:0] rf_wdata = '0;

    int checks = 0;
    int errors = 0;
    logic [15:0] model [8];
    logic [31:0] lfsr = 32'hACE1_2357;

    always #2 clk = ~clk;

    lu_load_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .busy(busy), .done(done), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata)
    );

    function automatic logic [15:0] memf(input logic [15:0] a);
        logic [31:0] p;
        p = {16'h0, a} * 32'h0000_9E37;
        return p[15:0] ^ 16'h5A5A;
    endfunction

    // Synchronous memory, one cycle of read latency.
    always @(posedge clk) mem_rdata <= memf(mem_addr);

    function automatic logic [15:0] rnd();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        lfsr = lfsr ^ (lfsr << 7) ^ (lfsr >> 9);
        return lfsr[15:0];
    endfunction

    task automatic check(input logic ok, input string tag,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        rf_we = 1'b1; rf_waddr = a; rf_wdata = d;
        @(negedge clk);
        rf_we = 1'b0;
        model[a] = d;
    endtask

    task automatic rd_check(input logic [2:0] a, input string tag);
        rf_raddr = a;
        #0.5;
        check(rf_rdata == model[a], tag, rf_rdata, model[a]);
    endtask

    // One load; poke=1 also drives a stray start and external write while busy.
    task automatic do_load(input logic mode, input logic [2:0] d,
                           input logic [2:0] b, input logic [2:0] x,
                           input logic [5:0] disp, input bit poke);
        logic [15:0] ea, word, sx;
        logic [2:0]  other;
        sx = {{10{disp[5]}}, disp};
        ea = model[b] + (mode ? model[x] : 16'h0) + sx;
        word = memf(ea);
        other = d + 3'd1;
        @(negedge clk);
        start = 1'b1; instr = {mode, d, b, x, disp};
        @(negedge clk);                  // ADDR
        start = 1'b0;
        check(busy == 1'b1, "R6 busy after start", {15'h0, busy}, 16'h1);
        if (poke) begin
            start = 1'b1; instr = ~instr;
            rf_we = 1'b1; rf_waddr = other; rf_wdata = ~model[other];
        end
        @(negedge clk);                  // READ
        start = 1'b0; rf_we = 1'b0;
        check(mem_rd == 1'b1, "R4 read strobe", {15'h0, mem_rd}, 16'h1);
        check(mem_addr == ea, mode ? "R2 indexed address" : "R3 plain address",
              mem_addr, ea);
        @(negedge clk);                  // CAPT
        check(mem_rd == 1'b0, "R4 read single cycle", {15'h0, mem_rd}, 16'h0);
        @(negedge clk);                  // WB
        check(busy == 1'b1 && done == 1'b0, "R6 busy through write-back",
              {14'h0, busy, done}, 16'h2);
        @(negedge clk);                  // DONE
        model[d] = word;
        check(busy == 1'b0 && done == 1'b1, "R6 done pulse",
              {14'h0, busy, done}, 16'h1);
        rd_check(d, "R5 destination loaded");
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R6 back to idle",
              {14'h0, busy, done}, 16'h0);
        if (poke) rd_check(other, "R7 external write ignored while busy");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 8; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: reset state
        check(busy == 1'b0 && done == 1'b0 && mem_rd == 1'b0, "R8 reset outputs",
              {13'h0, busy, done, mem_rd}, 16'h0);
        for (int i = 0; i < 8; i++) rd_check(3'(i), "R8 register reset zero");

        // R7: every register, including register 0, writable when idle.
        for (int i = 0; i < 8; i++) begin
            wr(3'(i), rnd());
            rd_check(3'(i), "R7 external write");
        end

        // R2/R3/R1: every displacement in both modes, fresh operands.
        for (int m = 0; m < 2; m++) begin
            for (int dsp = 0; dsp < 64; dsp++) begin
                logic [2:0] b, x, d;
                b = rnd()[2:0];
                x = b + 3'd1 + rnd()[1:0];
                d = rnd()[2:0];
                wr(b, rnd());
                wr(x, rnd());
                do_load(m[0], d, b, x, 6'(dsp), (dsp % 8) == 3);
            end
        end

        // R2: wrap modulo 2^16.
        wr(3'd1, 16'hFFF0); wr(3'd2, 16'h0020);
        do_load(1'b1, 3'd3, 3'd1, 3'd2, 6'h3F, 1'b0);
        // R3: base x3000 with offset 5 gives x3005, index ignored.
        wr(3'd4, 16'h3000); wr(3'd5, 16'h7777);
        do_load(1'b0, 3'd6, 3'd4, 3'd5, 6'd5, 1'b0);
        // R9: destination equals base, then equals index.
        wr(3'd0, 16'h1234); wr(3'd7, 16'h0100);
        do_load(1'b1, 3'd0, 3'd0, 3'd7, 6'h20, 1'b0);
        do_load(1'b1, 3'd7, 3'd0, 3'd7, 6'h01, 1'b0);
        // R5: every destination register.
        for (int d = 0; d < 8; d++) do_load(1'b1, 3'(d), 3'(d + 1), 3'(d + 2), 6'(d * 5), 1'b1);

        // R6: back-to-back starts, accepted in the done cycle.
        @(negedge clk);
        start = 1'b1; instr = {1'b0, 3'd2, 3'd4, 3'd0, 6'd1};
        repeat (5) @(negedge clk);
        check(done == 1'b1, "R6 done before restart", {15'h0, done}, 16'h1);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R6 start accepted in done cycle", {15'h0, busy}, 16'h1);
        repeat (6) @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule